// File: doc/BRIEF.md
# LCD Raster Timing Generator

This block produces the raster strobes that drive an LCD panel: horizontal sync, vertical sync and data enable, together with a panel-on level and a flag that selects which pixel-clock edge the panel should use for its data. It also provides free-running horizontal and vertical position counters that a pixel fetch stage can follow. One pixel is produced per `clk` cycle. Software sets up the geometry through three 32-bit timing words and starts the raster with a control bit. A simple write-only register port is used for this.

Each timing field carries its own bias. The active width is programmed in steps of 16 pixels. Most widths are stored as count minus one. The two vertical porches are stored as plain line counts.

The start address of the frame buffer is double-buffered. Software writes a pending value. The generator moves that value into the live address at the next frame start and raises a next-base-update interrupt status bit. This lets software prepare a flip at any time without tearing the frame that is being shown. The status bit has an enable mask and is cleared by writing a one to it.

Top module: `lcd_raster_timer`

## Requirements
- R1: Word address 3, bit 0 is the run enable. While run is 0, `lcd_on` is 0, `h_cnt` and `v_cnt` read 0, `frame_start` is 0, and each strobe sits at its inactive level. The inactive level is 0, or 1 when that strobe's invert bit is set.
- R2: Word address 0 holds the horizontal timing: ppl in [7:2], hsw in [15:8], hfp in [23:16], hbp in [31:24]. A line is hsw+1 sync clocks, then hbp+1 back-porch clocks, then 16*(ppl+1) active clocks, then hfp+1 front-porch clocks. `h_cnt` counts from 0 at the first sync clock and wraps to 0 after the last front-porch clock. `hsync` is asserted for exactly the sync clocks.
- R3: Word address 1 holds the vertical timing: lpp in [9:0], vsw in [15:10], vfp in [23:16], vbp in [31:24]. A frame is vsw+1 sync lines, then vbp back-porch lines, then lpp+1 active lines, then vfp front-porch lines. `v_cnt` advances only after the last clock of a line. `vsync` is asserted for exactly the sync lines.
- R4: Word address 2 holds a clocks-per-line field cpl in [25:16]. Data enable is asserted only when `v_cnt` is on an active line and `h_cnt` falls within the first cpl+1 clocks of the active region of the line.
- R5: Word address 2 also holds the invert bits: bit 0 inverts `hsync`, bit 1 inverts `vsync`, bit 2 inverts `de`, and bit 3 drives `clk_edge_inv` directly.
- R6: `frame_start` is a one-cycle pulse. It is high in the cycle where both counters are 0 while running, which is the first clock of vsync. It is also high in the first cycle after run is set.
- R7: A write to word address 4 only records a pending base and leaves `base_addr` unchanged. The pending value appears on `base_addr` in the cycle after the next `frame_start`. While run is 0, the pending value never loads.
- R8: Loading a pending base sets `irq_raw`. `irq` equals `irq_raw` AND the mask bit (word address 5, bit 0). Writing word address 6 with bit 0 = 1 clears `irq_raw`. Writing it with bit 0 = 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock, one pixel per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register word address |
| wr_data | input | 32 | Register write data |
| lcd_on | output | 1 | High while the raster runs |
| hsync | output | 1 | Horizontal sync, polarity per invert bit |
| vsync | output | 1 | Vertical sync, polarity per invert bit |
| de | output | 1 | Data enable, polarity per invert bit |
| clk_edge_inv | output | 1 | Selects the opposite pixel-clock edge for panel data |
| h_cnt | output | CNT_W | Pixel position within the line |
| v_cnt | output | CNT_W | Line position within the frame |
| frame_start | output | 1 | One-cycle pulse at the start of each frame |
| base_addr | output | BASE_W | Frame base address in use |
| irq_raw | output | 1 | Next-base-update status, before the mask |
| irq | output | 1 | Masked next-base-update interrupt |

## Verification
The assertions assume that the geometry stays fixed while the raster runs. A timing word that changes mid-frame would move the wrap points under the counters and break the step checks. The bench therefore writes the timing words only while run is 0. The step-and-wrap assertions also assume that a line is always much longer than one cycle, which every legal field value guarantees. The interrupt assertions assume that a clear is never written in the same cycle as a base load. The bench keeps its clear writes well away from any frame start.

// File: rtl/lcd_raster_pkg.sv
`timescale 1ns/1ps
// Package: shared register map and timing-field types for the LCD raster timer.
// Assumes a 32-bit register write port; field positions are fixed by the map.
package lcd_raster_pkg;

    localparam int REG_AW        = 3;   // word address width of the write port
    localparam int REG_DW        = 32;  // register data width
    localparam int PPL_UNIT_LOG2 = 4;   // active width is programmed in units of 16

    // Register word addresses
    typedef enum logic [REG_AW-1:0] {
        ADR_HTIM = 3'd0,
        ADR_VTIM = 3'd1,
        ADR_POL  = 3'd2,
        ADR_CTRL = 3'd3,
        ADR_BASE = 3'd4,
        ADR_IMSK = 3'd5,
        ADR_ICLR = 3'd6
    } reg_addr_e;

    // Horizontal timing fields (widths biased minus one, ppl in units of 16)
    typedef struct packed {
        logic [7:0] hbp;
        logic [7:0] hfp;
        logic [7:0] hsw;
        logic [5:0] ppl;
    } htim_t;

    // Vertical timing fields (lpp and vsw minus one, porches as-is)
    typedef struct packed {
        logic [7:0] vbp;
        logic [7:0] vfp;
        logic [5:0] vsw;
        logic [9:0] lpp;
    } vtim_t;

    // Polarity and clocks-per-line fields
    typedef struct packed {
        logic [9:0] cpl;
        logic       clk_inv;
        logic [2:0] str_inv;   // [0] hsync, [1] vsync, [2] data enable
    } pol_t;

endpackage

// File: rtl/lcd_reg_file.sv
`timescale 1ns/1ps
// Module: lcd_reg_file
// Holds the timing, polarity and control registers, the double-buffered
// frame base address and the next-base-update interrupt status and mask.
// Assumes: frame_start is a single-cycle pulse; writes are single-cycle.
module lcd_reg_file
    import lcd_raster_pkg::*;
#(
    parameter int BASE_W = 32
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [REG_DW-1:0] wr_data,
    input  logic              frame_start,
    output htim_t             htim,
    output vtim_t             vtim,
    output pol_t              pol,
    output logic              run,
    output logic [BASE_W-1:0] base_live,
    output logic              irq_raw,
    output logic              irq_mask
);

    logic [BASE_W-1:0] base_pend;
    logic              pend_q;
    logic              base_load;
    logic              sel_base;
    logic              sel_clr;

    assign sel_base  = wr_en && (reg_addr_e'(wr_addr) == ADR_BASE);
    assign sel_clr   = wr_en && (reg_addr_e'(wr_addr) == ADR_ICLR);
    assign base_load = frame_start && pend_q;

    // Capture timing, polarity, control and mask registers from the write port
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            htim     <= '0;
            vtim     <= '0;
            pol      <= '0;
            run      <= 1'b0;
            irq_mask <= 1'b0;
        end else if (wr_en) begin
            case (reg_addr_e'(wr_addr))
                ADR_HTIM: htim <= '{hbp: wr_data[31:24], hfp: wr_data[23:16],
                                    hsw: wr_data[15:8],  ppl: wr_data[7:2]};
                ADR_VTIM: vtim <= '{vbp: wr_data[31:24], vfp: wr_data[23:16],
                                    vsw: wr_data[15:10], lpp: wr_data[9:0]};
                ADR_POL:  pol  <= '{cpl: wr_data[25:16], clk_inv: wr_data[3],
                                    str_inv: wr_data[2:0]};
                ADR_CTRL: run      <= wr_data[0];
                ADR_IMSK: irq_mask <= wr_data[0];
                default:  ;
            endcase
        end
    end

    // Pending base capture and transfer into the live base at frame start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_pend <= '0;
            base_live <= '0;
            pend_q    <= 1'b0;
        end else begin
            if (base_load) begin
                base_live <= base_pend;
            end
            if (sel_base) begin
                base_pend <= wr_data[BASE_W-1:0];
                pend_q    <= 1'b1;
            end else if (frame_start) begin
                pend_q    <= 1'b0;
            end
        end
    end

    // Next-base-update status: set on load, write-one-to-clear, set wins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_raw <= 1'b0;
        end else if (base_load) begin
            irq_raw <= 1'b1;
        end else if (sel_clr && wr_data[0]) begin
            irq_raw <= 1'b0;
        end
    end

endmodule

// File: rtl/lcd_axis_counter.sv
`timescale 1ns/1ps
// Module: lcd_axis_counter
// Position counter for one raster axis: steps on 'step', wraps after 'last'.
// The output reads zero whenever 'run' is low so a stopped raster shows 0.
// Assumes: 'last' is stable while running (a larger held value still wraps).
module lcd_axis_counter #(
    parameter int CNT_W = 12
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             step,
    input  logic [CNT_W-1:0] last,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic             at_end;

    assign at_end = (cnt_q >= last);
    assign wrap   = run && step && at_end;
    assign cnt    = run ? cnt_q : '0;

    // Advance the position, restart at zero after the last step or when stopped
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= at_end ? '0 : cnt_q + ONE;
        end
    end

endmodule

// File: rtl/lcd_window_decode.sv
`timescale 1ns/1ps
// Module: lcd_window_decode
// Turns the timing fields into segment boundaries and decodes the raw
// (active-high, un-gated) sync and data-enable windows from the counters.
// Assumes: CNT_W is wide enough for the longest line and frame (12 bits).
module lcd_window_decode
    import lcd_raster_pkg::*;
#(
    parameter int CNT_W = 12
)(
    input  htim_t            htim,
    input  vtim_t            vtim,
    input  logic [9:0]       cpl,
    input  logic [CNT_W-1:0] h,
    input  logic [CNT_W-1:0] v,
    output logic [CNT_W-1:0] h_last,
    output logic [CNT_W-1:0] v_last,
    output logic             hs_win,
    output logic             vs_win,
    output logic             de_win
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] hs_end, ha_beg, ha_end, ha_w;
    logic [CNT_W-1:0] vs_end, va_beg, va_end;
    logic             h_act, v_act, h_in_cpl;

    // Horizontal boundaries: sync, back porch, active (16-pixel units), front porch
    always_comb begin
        hs_end = CNT_W'(htim.hsw) + ONE;
        ha_beg = hs_end + CNT_W'(htim.hbp) + ONE;
        ha_w   = (CNT_W'(htim.ppl) + ONE) << PPL_UNIT_LOG2;
        ha_end = ha_beg + ha_w;
        h_last = ha_end + CNT_W'(htim.hfp);
    end

    // Vertical boundaries: sync, back porch, active, front porch (porches unbiased)
    always_comb begin
        vs_end = CNT_W'(vtim.vsw) + ONE;
        va_beg = vs_end + CNT_W'(vtim.vbp);
        va_end = va_beg + CNT_W'(vtim.lpp) + ONE;
        v_last = va_end + CNT_W'(vtim.vfp) - ONE;
    end

    // Window decode from the current position
    always_comb begin
        hs_win   = (h < hs_end);
        vs_win   = (v < vs_end);
        h_act    = (h >= ha_beg) && (h < ha_end);
        h_in_cpl = ((h - ha_beg) <= CNT_W'(cpl));
        v_act    = (v >= va_beg) && (v < va_end);
        de_win   = h_act && h_in_cpl && v_act;
    end

endmodule

// File: rtl/lcd_raster_timer.sv
`timescale 1ns/1ps
// Module: lcd_raster_timer (top)
// LCD raster timing generator: register write port, horizontal and vertical
// counters, sync/data-enable strobes with programmable polarity, and the
// double-buffered frame base with its next-base-update interrupt.
// Assumes: one pixel per clk; geometry is rewritten only while stopped.
module lcd_raster_timer
    import lcd_raster_pkg::*;
#(
    parameter int CNT_W  = 12,
    parameter int BASE_W = 32
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [31:0]       wr_data,
    output logic              lcd_on,
    output logic              hsync,
    output logic              vsync,
    output logic              de,
    output logic              clk_edge_inv,
    output logic [CNT_W-1:0]  h_cnt,
    output logic [CNT_W-1:0]  v_cnt,
    output logic              frame_start,
    output logic [BASE_W-1:0] base_addr,
    output logic              irq_raw,
    output logic              irq
);

    localparam int NSTR = 3;

    htim_t            htim;
    vtim_t            vtim;
    pol_t             pol;
    logic             run;
    logic             irq_mask;
    logic [CNT_W-1:0] h_last, v_last;
    logic             h_wrap, v_wrap_unused;
    logic             hs_win, vs_win, de_win;
    logic [NSTR-1:0]  str_raw, str_out, str_inv;

    lcd_reg_file #(.BASE_W(BASE_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .frame_start(frame_start),
        .htim       (htim),
        .vtim       (vtim),
        .pol        (pol),
        .run        (run),
        .base_live  (base_addr),
        .irq_raw    (irq_raw),
        .irq_mask   (irq_mask)
    );

    lcd_axis_counter #(.CNT_W(CNT_W)) u_hcnt (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (run),
        .step (1'b1),
        .last (h_last),
        .cnt  (h_cnt),
        .wrap (h_wrap)
    );

    lcd_axis_counter #(.CNT_W(CNT_W)) u_vcnt (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (run),
        .step (h_wrap),
        .last (v_last),
        .cnt  (v_cnt),
        .wrap (v_wrap_unused)
    );

    lcd_window_decode #(.CNT_W(CNT_W)) u_dec (
        .htim  (htim),
        .vtim  (vtim),
        .cpl   (pol.cpl),
        .h     (h_cnt),
        .v     (v_cnt),
        .h_last(h_last),
        .v_last(v_last),
        .hs_win(hs_win),
        .vs_win(vs_win),
        .de_win(de_win)
    );

    assign str_raw = {de_win, vs_win, hs_win};
    assign str_inv = pol.str_inv;

    // Gate each strobe with run, then apply its polarity
    for (genvar i = 0; i < NSTR; i++) begin : g_pol
        assign str_out[i] = (run && str_raw[i]) ^ str_inv[i];
    end

    assign hsync        = str_out[0];
    assign vsync        = str_out[1];
    assign de           = str_out[2];
    assign clk_edge_inv = pol.clk_inv;
    assign lcd_on       = run;
    assign frame_start  = run && (h_cnt == '0) && (v_cnt == '0);
    assign irq          = irq_raw && irq_mask;

endmodule

// File: rtl/lcd_raster_checker.sv
`timescale 1ns/1ps
// Module: lcd_raster_checker
// Property checks on the raster timer, bound to the top module.
// Assumes: geometry registers are written only while the raster is stopped.
module lcd_raster_checker #(
    parameter int CNT_W  = 12,
    parameter int BASE_W = 32
)(
    input logic              clk,
    input logic              rst_n,
    input logic              lcd_on,
    input logic              hsync,
    input logic              vsync,
    input logic              de,
    input logic              frame_start,
    input logic              irq_raw,
    input logic              irq,
    input logic [CNT_W-1:0]  h_cnt,
    input logic [CNT_W-1:0]  v_cnt,
    input logic [BASE_W-1:0] base_addr,
    input logic [2:0]        str_inv
);

    // R1: a stopped raster shows zero counters and inactive strobes
    assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !lcd_on |-> (h_cnt == '0) && (v_cnt == '0) && !frame_start &&
                    (hsync == str_inv[0]) && (vsync == str_inv[1]) && (de == str_inv[2]));

    // R2: away from the wrap, the pixel counter steps by one each clock
    assert_hstep_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (lcd_on && $past(lcd_on) && (h_cnt != '0)) |-> (h_cnt == $past(h_cnt) + 1'b1));

    // R3: the line counter holds within a line
    assert_vhold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (lcd_on && $past(lcd_on) && (h_cnt != '0)) |-> $stable(v_cnt));

    // R4: data enable is never active during horizontal sync
    assert_de_out_of_sync_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (de != str_inv[2]) |-> (hsync == str_inv[0]));

    // R6: frame start lasts one cycle
    assert_fs_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !frame_start);

    // R7: the live base only moves right after a frame start
    assert_base_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(frame_start) |-> $stable(base_addr));

    // R8: a base change sets the status; the interrupt never fires without status
    assert_irq_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(frame_start) && !$stable(base_addr)) |-> irq_raw);

    assert_irq_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> irq_raw);

endmodule

bind lcd_raster_timer lcd_raster_checker #(.CNT_W(CNT_W), .BASE_W(BASE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lcd_on     (lcd_on),
    .hsync      (hsync),
    .vsync      (vsync),
    .de         (de),
    .frame_start(frame_start),
    .irq_raw    (irq_raw),
    .irq        (irq),
    .h_cnt      (h_cnt),
    .v_cnt      (v_cnt),
    .base_addr  (base_addr),
    .str_inv    (str_inv)
);

// File: tb/sim_lcd_raster_timer.sv
`timescale 1ns/1ps
// Directed bench for lcd_raster_timer: one task per scenario.
module sim_lcd_raster_timer;

    localparam int CNT_W  = 12;
    localparam int BASE_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [2:0]        wr_addr = '0;
    logic [31:0]       wr_data = '0;
    logic              lcd_on, hsync, vsync, de, clk_edge_inv, frame_start, irq_raw, irq;
    logic [CNT_W-1:0]  h_cnt, v_cnt;
    logic [BASE_W-1:0] base_addr;

    int total = 0;
    int bad   = 0;

    // current geometry as programmed
    int c_hsw, c_hbp, c_ppl, c_hfp, c_vsw, c_vbp, c_lpp, c_vfp, c_cpl;
    logic [3:0] c_inv;

    lcd_raster_timer #(.CNT_W(CNT_W), .BASE_W(BASE_W)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .lcd_on(lcd_on), .hsync(hsync), .vsync(vsync), .de(de), .clk_edge_inv(clk_edge_inv),
        .h_cnt(h_cnt), .v_cnt(v_cnt), .frame_start(frame_start), .base_addr(base_addr),
        .irq_raw(irq_raw), .irq(irq)
    );

    always #2.5 clk = ~clk;   // 200 MHz

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic program_geom(input int hsw, hbp, ppl, hfp, vsw, vbp, lpp, vfp, cpl, input logic [3:0] inv);
        c_hsw = hsw; c_hbp = hbp; c_ppl = ppl; c_hfp = hfp;
        c_vsw = vsw; c_vbp = vbp; c_lpp = lpp; c_vfp = vfp; c_cpl = cpl; c_inv = inv;
        wr(3'd3, 32'd0);
        wr(3'd0, (32'(hbp) << 24) | (32'(hfp) << 16) | (32'(hsw) << 8) | (32'(ppl) << 2));
        wr(3'd1, (32'(vbp) << 24) | (32'(vfp) << 16) | (32'(vsw) << 10) | 32'(lpp));
        wr(3'd2, (32'(cpl) << 16) | 32'(inv));
    endtask

    // Expected raster state n clocks after run was set, from the requirements
    function automatic void model(input int n, output int eh, output int ev,
                                  output bit ehs, output bit evs, output bit ede, output bit efs);
        int hl, vl, ab, ae, vab, vae;
        ab  = (c_hsw + 1) + (c_hbp + 1);
        ae  = ab + 16 * (c_ppl + 1);
        hl  = ae + c_hfp + 1;
        vab = (c_vsw + 1) + c_vbp;
        vae = vab + c_lpp + 1;
        vl  = vae + c_vfp;
        eh  = n % hl;
        ev  = (n / hl) % vl;
        ehs = eh < c_hsw + 1;
        evs = ev < c_vsw + 1;
        ede = (eh >= ab) && (eh < ae) && (eh - ab <= c_cpl) && (ev >= vab) && (ev < vae);
        efs = (eh == 0) && (ev == 0);
    endfunction

    // Start the raster and compare every output each cycle for ncyc cycles
    task automatic run_compare(input string tag, input int ncyc);
        int errs [6];
        logic [31:0] fa [6];
        logic [31:0] fe [6];
        int fc [6];
        string nm [6];
        logic [31:0] act [6];
        logic [31:0] exv [6];
        int eh, ev;
        bit ehs, evs, ede, efs;
        nm = '{"h_cnt R2", "hsync R2/R5", "v_cnt R3", "vsync R3/R5", "de R4/R5", "frame_start R6"};
        for (int i = 0; i < 6; i++) errs[i] = 0;
        wr(3'd3, 32'd1);
        for (int n = 0; n < ncyc; n++) begin
            model(n, eh, ev, ehs, evs, ede, efs);
            act = '{32'(h_cnt), 32'(hsync), 32'(v_cnt), 32'(vsync), 32'(de), 32'(frame_start)};
            exv = '{32'(eh), 32'(ehs ^ c_inv[0]), 32'(ev), 32'(evs ^ c_inv[1]),
                    32'(ede ^ c_inv[2]), 32'(efs)};
            for (int i = 0; i < 6; i++) begin
                if (act[i] !== exv[i]) begin
                    if (errs[i] == 0) begin fa[i] = act[i]; fe[i] = exv[i]; fc[i] = n; end
                    errs[i]++;
                end
            end
            @(negedge clk);
        end
        for (int i = 0; i < 6; i++) begin
            total++;
            if (errs[i] != 0) begin
                bad++;
                $display("FAIL %s %s at cycle %0d actual=%h expected=%h", tag, nm[i], fc[i], fa[i], fe[i]);
            end
        end
        chk("R1", {tag, " lcd_on while running"}, 32'(lcd_on), 32'd1);
        chk("R5", {tag, " clk_edge_inv"}, 32'(clk_edge_inv), 32'(c_inv[3]));
    endtask

    task automatic t_reset();
        chk("R1", "reset counters", {8'd0, 12'(h_cnt), 12'(v_cnt)}, 32'd0);
        chk("R1", "reset strobes", {27'd0, lcd_on, hsync, vsync, de, frame_start}, 32'd0);
        chk("R7", "reset base", base_addr, 32'd0);
        chk("R8", "reset irq", {30'd0, irq_raw, irq}, 32'd0);
    endtask

    task automatic t_frame_plain();
        program_geom(1, 2, 0, 0, 0, 2, 3, 1, 15, 4'b0000);
        run_compare("plain", 2 * 176 + 5);
    endtask

    task automatic t_frame_inverted_cpl();
        program_geom(0, 0, 1, 2, 1, 0, 2, 0, 7, 4'b1111);
        run_compare("inv_cpl", 2 * 185 + 5);
    endtask

    task automatic t_disable();
        program_geom(1, 2, 0, 0, 0, 2, 3, 1, 15, 4'b0111);
        wr(3'd3, 32'd1);
        repeat (60) @(negedge clk);
        chk("R1", "running before stop", 32'(lcd_on), 32'd1);
        wr(3'd3, 32'd0);
        chk("R1", "stopped counters", {8'd0, 12'(h_cnt), 12'(v_cnt)}, 32'd0);
        chk("R1", "stopped strobes inactive inverted", {28'd0, lcd_on, hsync, vsync, de}, 32'h7);
        repeat (20) @(negedge clk);
        chk("R1", "stopped stays idle", {27'd0, lcd_on, hsync, vsync, de, frame_start}, 32'he);
    endtask

    task automatic t_base_irq();
        int guard;
        logic [31:0] seen_change;
        program_geom(1, 2, 0, 0, 0, 2, 3, 1, 15, 4'b0000);
        wr(3'd5, 32'd0);
        wr(3'd4, 32'h1000_0040);
        repeat (20) @(negedge clk);
        chk("R7", "no load while stopped", base_addr, 32'd0);
        wr(3'd3, 32'd1);
        chk("R6", "frame_start on first run cycle", 32'(frame_start), 32'd1);
        chk("R7", "base old in frame-start cycle", base_addr, 32'd0);
        @(negedge clk);
        chk("R7", "base loaded after frame start", base_addr, 32'h1000_0040);
        chk("R8", "status set by load", 32'(irq_raw), 32'd1);
        chk("R8", "masked irq low", 32'(irq), 32'd0);
        wr(3'd5, 32'd1);
        chk("R8", "mask on raises irq", 32'(irq), 32'd1);
        wr(3'd6, 32'd0);
        chk("R8", "clear with zero ignored", {30'd0, irq_raw, irq}, 32'h3);
        wr(3'd6, 32'd1);
        chk("R8", "write-one clears", {30'd0, irq_raw, irq}, 32'h0);
        wr(3'd4, 32'h2222_0080);
        seen_change = 0;
        guard = 0;
        while (!frame_start && guard < 400) begin
            if (base_addr !== 32'h1000_0040) seen_change++;
            @(negedge clk);
            guard++;
        end
        chk("R7", "base held until frame start", seen_change, 32'd0);
        chk("R6", "next frame start reached", 32'(frame_start), 32'd1);
        chk("R7", "base still old at frame start", base_addr, 32'h1000_0040);
        @(negedge clk);
        chk("R7", "second base loaded", base_addr, 32'h2222_0080);
        chk("R8", "second load raises irq", {30'd0, irq_raw, irq}, 32'h3);
        repeat (200) @(negedge clk);
        chk("R7", "no reload without new write", base_addr, 32'h2222_0080);
        wr(3'd3, 32'd0);
    endtask

    // Watchdog: a hung run ends as a failure
    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_frame_plain();
        t_frame_inverted_cpl();
        t_disable();
        t_base_irq();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule